// File: doc/BRIEF.md
# Cascaded Master Clock Prescaler

This block takes one fast master clock and produces, in that same clock domain, a set of single-cycle enable pulses. The first is an internal master clock enable whose rate is the input rate divided by the product of three series divider stages. The first two stages each divide by 1, 2 or 3. The last stage divides by 1, 2 or 4. The other enables are fixed sub-rates of that internal enable: a DAC modulator enable at one half, an ADC modulator enable at one quarter, and a frame (sample) strobe at 1/256. A fast mode shortens the frame to 128 internal enables. Downstream logic uses these enables in place of gated clocks.

The divider selection comes in as a parallel 10-bit configuration word. Only its low six bits are used. The configuration word and the fast-frame flag are sampled while reset is held. After reset they are taken up only on a frame boundary, so the block never emits a partial frame and the cascade never skips or stretches a pulse. All the pins are plain control and strobe pins. No data stream passes through the block, so no handshake is involved.

Top module: `mclk_prescale_chain`

## Requirements
- R1: Stage one uses cfg_word[1:0] and stage two uses cfg_word[3:2]. Each field is encoded 00 = divide by 1, 01 = divide by 2, 10 = divide by 3, 11 = divide by 1.
- R2: Stage three uses cfg_word[5:4], encoded 00 = divide by 1, 01 = divide by 2, 10 = divide by 4, 11 = divide by 1.
- R3: imclk_en pulses once every N input cycles, where N is the product of the three stage ratios. For example, divide by 3 in stage one and divide by 2 in stage two give N = 6.
- R4: With fast_frame low, frame_stb pulses on every 256th imclk_en pulse and always coincides with an imclk_en pulse.
- R5: With fast_frame high, frame_stb pulses on every 128th imclk_en pulse.
- R6: dac_mod_en pulses on every 2nd imclk_en pulse and adc_mod_en on every 4th. Each is high only together with imclk_en. In the cycle of frame_stb, all four enables are high.
- R7: Changes to cfg_word and fast_frame made after reset take effect from the cycle that follows the next frame_stb. Until then, the old periods hold.
- R8: While rst_n is low, all four outputs are low and every counter is cleared. Once rst_n is high, the first imclk_en appears in the Nth cycle (cycle index N-1, counting from the first cycle with rst_n high). The first frame_stb appears at cycle index N*P-1, where P is the frame length.
- R9: cfg_word[9:6] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | 10 | Divider selection word; bits 5:0 used |
| fast_frame | input | 1 | Selects a 128-cycle frame instead of 256 |
| imclk_en | output | 1 | Internal master clock enable |
| dac_mod_en | output | 1 | DAC modulator enable (imclk/2) |
| adc_mod_en | output | 1 | ADC modulator enable (imclk/4) |
| frame_stb | output | 1 | Sample strobe (imclk/256 or /128) |

## Verification
A stage counter that is off by one would show at once as a wrong spacing between imclk_en pulses, within one cascaded period. The same fault in the sub-rate counter would shift the first frame_stb away from index N*P-1, or split it from the ADC and DAC enables, within one frame. A configuration register that takes a new value mid-frame would change the imclk_en spacing before the frame strobe. The bench looks for that change in the first frame after the new value is applied.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  // Two divider variants exist in the chain.
  typedef enum logic [0:0] {
    KIND_ODD  = 1'b0,   // divide 1 / 2 / 3
    KIND_POW2 = 1'b1    // divide 1 / 2 / 4
  } stage_kind_e;

  localparam int NUM_STAGES  = 3;
  localparam int SEL_W       = 2;
  localparam int CFG_W       = 10;
  localparam int USED_CFG_W  = NUM_STAGES * SEL_W;
  localparam int RATIO_W     = 3;
  localparam int CNT_W       = 2;

  localparam int FRAME_LOG2  = 8;
  localparam int FAST_LOG2   = 7;
  localparam int ADC_LOG2    = 2;
  localparam int DAC_LOG2    = 1;

  function automatic stage_kind_e kind_of(input int idx);
    return (idx == NUM_STAGES - 1) ? KIND_POW2 : KIND_ODD;
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input stage_kind_e kind,
                                                  input logic [SEL_W-1:0] sel);
    logic [RATIO_W-1:0] r;
    case (sel)
      2'b01:   r = 3'd2;
      2'b10:   r = (kind == KIND_POW2) ? 3'd4 : 3'd3;
      default: r = 3'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/presc_stage.sv
module presc_stage
  import prescale_pkg::*;
#(
  parameter stage_kind_e KIND = KIND_ODD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  input  logic [SEL_W-1:0] sel,
  output logic             out_en
);

  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] last_full;
  logic [CNT_W-1:0]   last;
  logic [CNT_W-1:0]   cnt;
  logic               at_term;

  always_comb begin
    ratio     = ratio_of(KIND, sel);
    last_full = ratio - 3'd1;
    last      = last_full[CNT_W-1:0];
    at_term   = (cnt == last);
    out_en    = in_en & at_term;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (in_en)
      cnt <= at_term ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/presc_cfg_hold.sv
module presc_cfg_hold
  import prescale_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  boundary,
  input  logic [USED_CFG_W-1:0] cfg_in,
  input  logic                  fast_in,
  output logic [USED_CFG_W-1:0] cfg_act,
  output logic                  fast_act
);

  // Sample while in reset, then only on a frame boundary.
  always_ff @(posedge clk) begin
    if (!rst_n || boundary) begin
      cfg_act  <= cfg_in;
      fast_act <= fast_in;
    end
  end

endmodule

// File: rtl/presc_subrate.sv
module presc_subrate
  import prescale_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fast,
  output logic dac_en,
  output logic adc_en,
  output logic frame_en
);

  logic [FRAME_LOG2-1:0] sub_cnt;
  logic                  end_full;
  logic                  end_fast;

  always_comb begin
    end_full = &sub_cnt;
    end_fast = &sub_cnt[FAST_LOG2-1:0];
    dac_en   = tick & (&sub_cnt[DAC_LOG2-1:0]);
    adc_en   = tick & (&sub_cnt[ADC_LOG2-1:0]);
    frame_en = tick & (fast ? end_fast : end_full);
  end

  // Restart on every frame so a length switch never leaves a partial frame.
  always_ff @(posedge clk) begin
    if (!rst_n)
      sub_cnt <= '0;
    else if (tick)
      sub_cnt <= frame_en ? '0 : sub_cnt + 1'b1;
  end

endmodule

// File: rtl/mclk_prescale_chain.sv
module mclk_prescale_chain
  import prescale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             fast_frame,
  output logic             imclk_en,
  output logic             dac_mod_en,
  output logic             adc_mod_en,
  output logic             frame_stb
);

  logic [USED_CFG_W-1:0] act_fields;
  logic                  act_fast;
  logic [NUM_STAGES:0]   chain_en;
  logic                  tick;
  logic                  sub_dac, sub_adc, sub_frame;
  logic                  unused_hi;

  assign unused_hi = ^cfg_word[CFG_W-1:USED_CFG_W];

  presc_cfg_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (sub_frame),
    .cfg_in   (cfg_word[USED_CFG_W-1:0]),
    .fast_in  (fast_frame),
    .cfg_act  (act_fields),
    .fast_act (act_fast)
  );

  assign chain_en[0] = 1'b1;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    presc_stage #(.KIND(kind_of(g))) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_en  (chain_en[g]),
      .sel    (act_fields[g*SEL_W +: SEL_W]),
      .out_en (chain_en[g+1])
    );
  end

  assign tick = rst_n & chain_en[NUM_STAGES];

  presc_subrate u_sub (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .fast     (act_fast),
    .dac_en   (sub_dac),
    .adc_en   (sub_adc),
    .frame_en (sub_frame)
  );

  assign imclk_en   = tick;
  assign dac_mod_en = sub_dac;
  assign adc_mod_en = sub_adc;
  assign frame_stb  = sub_frame;

endmodule

// File: rtl/presc_checker.sv
module presc_checker
  import prescale_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  imclk_en,
  input logic                  dac_mod_en,
  input logic                  adc_mod_en,
  input logic                  frame_stb,
  input logic [USED_CFG_W-1:0] act_fields,
  input logic                  act_fast,
  input logic [NUM_STAGES:0]   chain_en
);

  logic [RATIO_W-1:0]    gap1;
  logic [RATIO_W-1:0]    r1;
  logic [FRAME_LOG2:0]   ic;

  assign r1 = ratio_of(kind_of(0), act_fields[SEL_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n || chain_en[1])
      gap1 <= '0;
    else if (gap1 != 3'd7)
      gap1 <= gap1 + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_stb)
      ic <= '0;
    else if (imclk_en)
      ic <= ic + 1'b1;
  end

  // R1: stage one pulse spacing matches its selected ratio
  assert_stage1_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chain_en[1] |-> (gap1 == r1 - 3'd1));

  // R3: later stages only pulse together with their feeder
  assert_chain_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_en[3] |-> chain_en[2] && chain_en[1]);

  // R4 / R5: frame strobe closes a frame of the active length
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (ic == (act_fast ? 9'd127 : 9'd255)));

  // R6: sub-rate enables nest
  assert_dac_in_imclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_mod_en |-> imclk_en);
  assert_adc_in_dac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_mod_en |-> dac_mod_en);
  assert_frame_in_adc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> adc_mod_en);

  // R7: active settings only move on a frame boundary
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(act_fields) && $stable(act_fast));

  // R8: quiet outputs during reset
  always @(posedge clk) begin
    if (!rst_n)
      assert_quiet_reset_R8: assert (!imclk_en && !dac_mod_en && !adc_mod_en && !frame_stb);
  end

endmodule

bind mclk_prescale_chain presc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imclk_en   (imclk_en),
  .dac_mod_en (dac_mod_en),
  .adc_mod_en (adc_mod_en),
  .frame_stb  (frame_stb),
  .act_fields (act_fields),
  .act_fast   (act_fast),
  .chain_en   (chain_en)
);

// File: tb/tb_mclk_prescale_chain.sv
module tb_mclk_prescale_chain;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cfg_word = '0;
  logic       fast_frame = 1'b0;
  logic       imclk_en, dac_mod_en, adc_mod_en, frame_stb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mclk_prescale_chain dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_word   (cfg_word),
    .fast_frame (fast_frame),
    .imclk_en   (imclk_en),
    .dac_mod_en (dac_mod_en),
    .adc_mod_en (adc_mod_en),
    .frame_stb  (frame_stb)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [9:0] cfg, input logic ff);
    @(negedge clk);
    rst_n      = 1'b0;
    cfg_word   = cfg;
    fast_frame = ff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R8: outputs low while reset is held
  task automatic t_reset_quiet();
    @(negedge clk);
    rst_n    = 1'b0;
    cfg_word = '0;
    repeat (4) begin
      @(negedge clk);
      check_eq("R8 reset imclk_en", int'(imclk_en), 0);
      check_eq("R8 reset frame_stb", int'(frame_stb | adc_mod_en | dac_mod_en), 0);
    end
  endtask

  task automatic t_ratio(input logic [9:0] cfg, input logic ff, input int n,
                         input string tag);
    int p = ff ? 128 : 256;
    int first_im = -1, prev = -1, per_bad = 0, frame_idx = -1;
    int im_cnt = 0, dac_cnt = 0, adc_cnt = 0, nest_bad = 0, coinc = 0;
    apply_reset(cfg, ff);
    for (int idx = 0; idx < n * p + 2; idx++) begin
      #1;
      if (imclk_en) begin
        if (first_im < 0) first_im = idx;
        else if (idx - prev != n) per_bad++;
        prev = idx;
        if (frame_idx < 0) im_cnt++;
      end
      if (frame_idx < 0) begin
        if (dac_mod_en) dac_cnt++;
        if (adc_mod_en) adc_cnt++;
      end
      if ((dac_mod_en || adc_mod_en) && !imclk_en) nest_bad++;
      if (frame_stb && frame_idx < 0) begin
        frame_idx = idx;
        coinc = int'(imclk_en & adc_mod_en & dac_mod_en);
      end
      @(negedge clk);
    end
    check_eq({tag, " R8 first imclk index"}, first_im, n - 1);
    check_eq({tag, " R3 imclk spacing errors"}, per_bad, 0);
    check_eq({tag, ff ? " R5 first frame index" : " R4 first frame index"}, frame_idx, n * p - 1);
    check_eq({tag, " R4 imclk per frame"}, im_cnt, p);
    check_eq({tag, " R6 dac per frame"}, dac_cnt, p / 2);
    check_eq({tag, " R6 adc per frame"}, adc_cnt, p / 4);
    check_eq({tag, " R6 frame coincidence"}, coinc, 1);
    check_eq({tag, " R6 nesting errors"}, nest_bad, 0);
  endtask

  // R7: new settings wait for the frame boundary
  task automatic t_boundary_change();
    int bad_old = 0, prev = -1, frame_idx = -1, second_frame = -1, first_new = -1;
    apply_reset(10'b00_0000_0001, 1'b0);   // stage one divide by 2
    for (int idx = 0; idx < 960; idx++) begin
      #1;
      if (idx == 100) begin
        cfg_word   = 10'b00_0000_0010;     // stage one divide by 3
        fast_frame = 1'b1;
      end
      if (imclk_en) begin
        if (idx <= 511 && prev >= 0 && idx - prev != 2) bad_old++;
        if (idx > 511 && first_new < 0) first_new = idx;
        prev = idx;
      end
      if (frame_stb) begin
        if (frame_idx < 0) frame_idx = idx;
        else if (second_frame < 0) second_frame = idx;
      end
      @(negedge clk);
    end
    check_eq("R7 old spacing held before boundary", bad_old, 0);
    check_eq("R7 first frame on old settings", frame_idx, 511);
    check_eq("R7 first imclk with new ratio", first_new, 514);
    check_eq("R7 R5 second frame uses new length", second_frame, 895);
  endtask

  initial begin
    t_reset_quiet();
    t_ratio(10'b00_0000_0000, 1'b0, 1, "all-pass");
    t_ratio(10'b00_0000_0001, 1'b0, 2, "R1 s1 div2");
    t_ratio(10'b00_0000_0010, 1'b0, 3, "R1 s1 div3");
    t_ratio(10'b00_0000_1000, 1'b0, 3, "R1 s2 div3");
    t_ratio(10'b00_0000_1111, 1'b0, 1, "R1 code11 pass");
    t_ratio(10'b00_0010_0000, 1'b0, 4, "R2 s3 div4");
    t_ratio(10'b00_0001_0000, 1'b0, 2, "R2 s3 div2");
    t_ratio(10'b00_0011_0000, 1'b0, 1, "R2 s3 code11");
    t_ratio(10'b00_0000_0110, 1'b0, 6, "R3 div3x2");
    t_ratio(10'b00_0010_1010, 1'b0, 36, "R3 div3x3x4");
    t_ratio(10'b00_0000_0001, 1'b1, 2, "R5 fast");
    t_ratio(10'b11_1100_0110, 1'b0, 6, "R9 upper bits");
    t_boundary_change();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule